// File: doc/BRIEF.md
# Pulse-Swallow Dual-Modulus Feedback Divider

This block is the programmable feedback divider of a frequency synthesizer loop. A fast input clock stands for the VCO. It passes through a dual-modulus prescaler that is modelled as a synchronous stage inside the block. That stage counts either P or P+1 input cycles per output cycle. A swallow counter picks the modulus and a main counter counts prescaler cycles. Together they give a total ratio of N = B·P + A. The block emits one single-cycle pulse every N input cycles.

At each period boundary the block captures the swallow value, the main value and the prescaler-size select. The first A prescaler cycles of the period use P+1 and the rest use P. A counter-reset input and a power-down input each hold both counters in their load state and keep the output quiet. When the hold is released, counting starts at once and stays aligned to the release edge. A registered flag marks a setting in which the main value is smaller than the swallow value.

Top module: `pswal_divider`

## Requirements
- R1: With 1 ≤ B and A ≤ B, consecutive output pulses are exactly B·P + A input cycles apart.
- R2: With the band parameter at 0, select 0 gives P = 8 and select 1 gives P = 16. With the band parameter at 1, select 0 gives P = 32 and select 1 gives P = 64.
- R3: The swallow value A is 6 bits wide (0..63) and the main value B is 11 bits wide (0..2047). Both extremes produce the ratio of R1.
- R4: Each output pulse is high for exactly one input-clock cycle.
- R5: While the counter reset is high, the output stays low. After the reset is released, the first pulse appears on the N-th rising edge after release, and the following pulses are spaced N apart.
- R6: The power-down input acts like R5: the output stays low while it is high, and the first pulse comes N edges after release.
- R7: A, B and select values applied in the middle of a period do not change that period. They set the length of the next period.
- R8: The flag output goes high one cycle after B < A is applied and low one cycle after B ≥ A is applied. With A > B, the period is B·(P+1).
- R9: A main value of 0 is treated as 1, so A = 0 and B = 0 give a period of P.
- R10: The asynchronous active-low reset drives the output and the flag low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast input clock standing for the VCO |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_rst | input | 1 | Holds both counters in load state while high |
| pwr_dn | input | 1 | Power-down force, holds counters in load state |
| psel | input | 1 | Prescaler size: 0 smaller pair, 1 larger pair |
| a_val | input | 6 | Swallow count A |
| b_val | input | 11 | Main count B |
| div_out | output | 1 | One-cycle pulse per N input cycles |
| cfg_bad | output | 1 | Registered flag, high when B < A |

## Verification
An internal fault always shows up as a wrong distance between output pulses. A swallow counter that stops early or late changes the period by a few cycles. A wrong modulus in the prescaler changes the period by a multiple of B. A main counter that skips a value changes it by P or P+1. In every case the fault is visible at the second pulse after the setting takes effect, so at most two periods pass before it shows. Faults in the hold and release paths appear at the first pulse after release, which is compared with N counted from the release edge.

// File: rtl/pswal_pkg.sv
package pswal_pkg;
  typedef enum logic {
    ST_LOAD  = 1'b0,
    ST_COUNT = 1'b1
  } div_state_e;
endpackage

// File: rtl/dm_prescaler.sv
module dm_prescaler #(
  parameter int PC_W   = 7,
  parameter int MAX_M1 = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic            load,
  input  logic [PC_W-1:0] len_m1,
  output logic            tick
);
  logic [PC_W-1:0] pc_q, pc_d;
  logic            pc_en;

  assign tick = run && (pc_q == '0);

  always_comb begin
    pc_d  = pc_q;
    pc_en = 1'b0;
    if (load) begin
      pc_d  = len_m1;
      pc_en = 1'b1;
    end else if (run) begin
      pc_d  = pc_q - 1'b1;
      pc_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pc_q <= '0;
    else if (pc_en) pc_q <= pc_d;
  end

  // R2: a prescaler cycle never runs longer than the largest modulus.
  p_len_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pc_q <= PC_W'(MAX_M1));
endmodule

// File: rtl/swallow_ctrl.sv
module swallow_ctrl
  import pswal_pkg::*;
#(
  parameter int A_W     = 6,
  parameter int B_W     = 11,
  parameter int PC_W    = 7,
  parameter int P_SMALL = 8,
  parameter int P_LARGE = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            hold_req,
  input  logic            tick,
  input  logic            psel,
  input  logic [A_W-1:0]  a_val,
  input  logic [B_W-1:0]  b_val,
  output logic            run,
  output logic            pre_load,
  output logic [PC_W-1:0] len_m1,
  output logic            wrap
);
  localparam logic [PC_W-1:0] PS_M1 = PC_W'(P_SMALL - 1);
  localparam logic [PC_W-1:0] PL_M1 = PC_W'(P_LARGE - 1);

  div_state_e     st_q, st_d;
  logic [A_W-1:0] a_q, a_d, a_dec;
  logic [B_W-1:0] b_q, b_d;
  logic           ps_q, ps_d;
  logic           cnt_en, reload;

  assign run    = (st_q == ST_COUNT) && !hold_req;
  assign wrap   = run && tick && (b_q == B_W'(1));
  assign reload = !run || wrap;
  assign a_dec  = (a_q != '0) ? a_q - 1'b1 : '0;
  assign st_d   = ST_COUNT;
  assign pre_load = reload || tick;

  always_comb begin
    a_d    = a_q;
    b_d    = b_q;
    ps_d   = ps_q;
    cnt_en = 1'b0;
    len_m1 = ps_q ? PL_M1 : PS_M1;
    if (reload) begin
      a_d    = a_val;
      b_d    = (b_val == '0) ? B_W'(1) : b_val;
      ps_d   = psel;
      cnt_en = 1'b1;
      len_m1 = (psel ? PL_M1 : PS_M1) + PC_W'(a_val != '0);
    end else if (tick) begin
      a_d    = a_dec;
      b_d    = b_q - 1'b1;
      cnt_en = 1'b1;
      len_m1 = (ps_q ? PL_M1 : PS_M1) + PC_W'(a_dec != '0);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_LOAD;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q  <= '0;
      b_q  <= '0;
      ps_q <= 1'b0;
    end else if (cnt_en) begin
      a_q  <= a_d;
      b_q  <= b_d;
      ps_q <= ps_d;
    end
  end

  // R9: once loaded, the main counter never holds zero.
  p_bcnt_live_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_COUNT) |-> (b_q != '0));
  // R7: the captured prescaler select only moves at a load boundary.
  p_sel_latched_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !wrap) |=> $stable(ps_q));
endmodule

// File: rtl/pswal_divider.sv
module pswal_divider #(
  parameter int A_W       = 6,
  parameter int B_W       = 11,
  parameter bit HIGH_BAND = 1'b0
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cnt_rst,
  input  logic           pwr_dn,
  input  logic           psel,
  input  logic [A_W-1:0] a_val,
  input  logic [B_W-1:0] b_val,
  output logic           div_out,
  output logic           cfg_bad
);
  localparam int P_SMALL = HIGH_BAND ? 32 : 8;
  localparam int P_LARGE = 2 * P_SMALL;
  localparam int PC_W    = $clog2(P_LARGE + 1);

  logic            run, pre_load, tick, wrap, hold_req;
  logic [PC_W-1:0] len_m1;
  logic            out_d, bad_d;

  assign hold_req = cnt_rst || pwr_dn;

  swallow_ctrl #(
    .A_W(A_W), .B_W(B_W), .PC_W(PC_W), .P_SMALL(P_SMALL), .P_LARGE(P_LARGE)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .hold_req(hold_req), .tick(tick),
    .psel(psel), .a_val(a_val), .b_val(b_val),
    .run(run), .pre_load(pre_load), .len_m1(len_m1), .wrap(wrap)
  );

  dm_prescaler #(.PC_W(PC_W), .MAX_M1(P_LARGE)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(run), .load(pre_load),
    .len_m1(len_m1), .tick(tick)
  );

  assign out_d = wrap;
  assign bad_d = (b_val < B_W'(a_val));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_out <= 1'b0;
      cfg_bad <= 1'b0;
    end else begin
      div_out <= out_d;
      cfg_bad <= bad_d;
    end
  end

  // R4: a pulse lasts a single input cycle.
  p_one_wide_r4: assert property (@(posedge clk) disable iff (!rst_n)
    div_out |=> !div_out);
  // R5 / R6: a hold request silences the output.
  p_quiet_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_rst || pwr_dn) |=> !div_out);
endmodule

// File: tb/pswal_divider_test.sv
module pswal_divider_test;
  logic        clk = 1'b0;
  logic        rst_n, cnt_rst, pwr_dn, psel;
  logic [5:0]  a_val;
  logic [10:0] b_val;
  logic        d_lf, bad_lf, d_hf, bad_hf;
  int          n_chk = 0;
  int          n_bad = 0;

  always #5 clk = ~clk;

  pswal_divider #(.HIGH_BAND(1'b0)) uut (
    .clk(clk), .rst_n(rst_n), .cnt_rst(cnt_rst), .pwr_dn(pwr_dn),
    .psel(psel), .a_val(a_val), .b_val(b_val), .div_out(d_lf), .cfg_bad(bad_lf)
  );

  pswal_divider #(.HIGH_BAND(1'b1)) uut_hf (
    .clk(clk), .rst_n(rst_n), .cnt_rst(cnt_rst), .pwr_dn(pwr_dn),
    .psel(psel), .a_val(a_val), .b_val(b_val), .div_out(d_hf), .cfg_bad(bad_hf)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic out_of(input bit hf);
    return hf ? d_hf : d_lf;
  endfunction

  task automatic wait_pulse(input bit hf);
    for (int i = 0; i < 40000; i++) begin
      @(negedge clk);
      if (out_of(hf)) break;
    end
  endtask

  task automatic count_gap(input bit hf, output int n);
    n = 0;
    for (int i = 0; i < 40000; i++) begin
      @(negedge clk);
      n++;
      if (out_of(hf)) break;
    end
  endtask

  task automatic measure(input bit hf, input int exp, input string tag);
    int n;
    wait_pulse(hf);
    count_gap(hf, n);
    check(n == exp, tag, n, exp);
  endtask

  task automatic set_cfg(input int a, input int b, input bit s);
    a_val = 6'(a);
    b_val = 11'(b);
    psel  = s;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; cnt_rst = 1'b0; pwr_dn = 1'b0;
    set_cfg(5, 2, 1'b0);
    repeat (3) @(negedge clk);
    check(d_lf == 1'b0 && bad_lf == 1'b0, "R10 reset state", {d_lf, bad_lf}, 0);
    set_cfg(0, 4, 1'b0);
    rst_n = 1'b1;
  endtask

  task automatic t_ratio();
    measure(1'b0, 32, "R1 A0 B4 P8");
    set_cfg(3, 10, 1'b0);
    measure(1'b0, 83, "R1 A3 B10 P8");
    set_cfg(7, 9, 1'b1);
    measure(1'b0, 151, "R1 A7 B9 P16");
  endtask

  task automatic t_band();
    set_cfg(10, 20, 1'b0);
    measure(1'b1, 650, "R2 high band P32");
    set_cfg(10, 20, 1'b1);
    measure(1'b1, 1290, "R2 high band P64");
    measure(1'b0, 330, "R2 low band P16");
  endtask

  task automatic t_width();
    set_cfg(63, 100, 1'b0);
    measure(1'b0, 863, "R3 A max");
    set_cfg(0, 2047, 1'b0);
    measure(1'b0, 16376, "R3 B max");
  endtask

  task automatic t_pulse();
    set_cfg(2, 5, 1'b0);
    wait_pulse(1'b0);
    @(negedge clk);
    check(d_lf == 1'b0, "R4 pulse one cycle", d_lf, 0);
  endtask

  task automatic t_hold(input bit use_pd, input int a, input int b, input bit s,
                        input int exp, input string tag);
    int k;
    int hi = 0;
    if (use_pd) pwr_dn = 1'b1; else cnt_rst = 1'b1;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (d_lf) hi++;
    end
    check(hi == 0, {tag, " quiet while held"}, hi, 0);
    set_cfg(a, b, s);
    @(negedge clk);
    cnt_rst = 1'b0; pwr_dn = 1'b0;
    count_gap(1'b0, k);
    check(k == exp, {tag, " first pulse after release"}, k, exp);
    count_gap(1'b0, k);
    check(k == exp, {tag, " second interval"}, k, exp);
  endtask

  task automatic t_boundary();
    int n;
    set_cfg(2, 5, 1'b0);
    measure(1'b0, 42, "R7 settle");
    set_cfg(4, 6, 1'b0);
    count_gap(1'b0, n);
    check(n == 42, "R7 current period unchanged", n, 42);
    count_gap(1'b0, n);
    check(n == 52, "R7 next period new", n, 52);
  endtask

  task automatic t_flag();
    set_cfg(5, 3, 1'b0);
    @(negedge clk);
    check(bad_lf == 1'b1, "R8 flag set on B<A", bad_lf, 1);
    measure(1'b0, 27, "R8 period B*(P+1)");
    set_cfg(3, 5, 1'b0);
    @(negedge clk);
    check(bad_lf == 1'b0, "R8 flag clear on B>=A", bad_lf, 0);
  endtask

  task automatic t_zero();
    set_cfg(0, 0, 1'b0);
    measure(1'b0, 8, "R9 B zero acts as one");
    check(bad_lf == 1'b0, "R9 no flag for A0 B0", bad_lf, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_ratio();
    t_band();
    t_width();
    t_pulse();
    t_hold(1'b0, 2, 5, 1'b0, 42, "R5");
    t_hold(1'b1, 1, 3, 1'b1, 49, "R6");
    t_boundary();
    t_flag();
    t_zero();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule